// File: doc/BRIEF.md
# Multiframe Descriptor Flow Controller

This block keeps the receive and transmit halves of a framed TDM line core busy with buffer descriptors. A descriptor names one 16-frame multiframe slot in a shared frame buffer. For each direction the controller issues descriptors to the line core, collects the ones the core hands back as finished, and keeps its own count of descriptors in flight. A ring tracker outside the block owns the buffer pointers. The controller reads its fill levels and the next multiframe index, and sends it strobes to allocate, commit, peek, release and realign.

Each direction runs its own four-state sequence: idle, boot, run and recover. Receive starts running on the cycle after it boots. On a loss of alignment or an overflow it drains every outstanding descriptor before it realigns the ring. Transmit starts running only once five multiframes are queued. After an underflow it waits until that much data is queued again. Whenever a direction moves back to run, the controller pulses a flag-clear strobe for that direction. Every output is decided in the same cycle from the current state and the inputs, and the state is registered.

Top module: `mfdc_top`

## Requirements
- R1: A submitted descriptor word carries the multiframe index from the tracker in bits 6:0, with bits 15:7 zero. A returned word has a done flag in bit 15 and two CRC-good flags in bits 14 and 13.
- R2: While the controller is active, a return pop is asserted in exactly those cycles where the returned word has bit 15 set (one pop per cycle). A receive pop is the commit strobe and a transmit pop is the release strobe.
- R3: At most 4 descriptors are in flight per direction. A direction issues at most one descriptor per cycle, only in run state, only while its count is below 4 and its tracker level is at least 16 frames (free frames for receive, unseen frames for transmit).
- R4: Transmit stays in boot until the unseen level is at least 80 frames. In that cycle it pulses its flag clear and enters run.
- R5: Receive spends exactly one cycle in boot. In that cycle it pulses its flag clear and then enters run.
- R6: In run, receive moves to recover in any cycle where the aligned input is low or the overflow input is high. It issues nothing in that cycle or while it is in recover.
- R7: Receive recover waits until its in-flight count is zero. In that cycle it pulses the realign strobe and its flag clear together, then enters run.
- R8: In run, transmit moves to recover when underflow is high and issues nothing in recover. It leaves recover with a flag-clear pulse in the first cycle where unseen is at least 80.
- R9: A receive pop whose word has bit 14 or bit 13 clear raises crcError in that same cycle. The flow carries on unchanged.
- R10: After reset both directions are idle: no pop, issue, realign or clear happens, and returned words are ignored, until enable is sampled high. Enable then moves both directions to boot. Enable is ignored while either direction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Starts both directions from idle |
| rxAligned | input | 1 | Receive framer is aligned |
| rxOverflow | input | 1 | Receive overflow flag |
| txUnderflow | input | 1 | Transmit underflow flag |
| rxFreeFrames | input | 8 | Receive ring free frames |
| rxNextMf | input | 7 | Next receive multiframe slot to allocate |
| txUnseenFrames | input | 8 | Transmit ring frames not yet peeked |
| txNextMf | input | 7 | Next transmit multiframe slot to peek |
| rxRetWord | input | 16 | Head of the receive return queue |
| txRetWord | input | 16 | Head of the transmit return queue |
| rxSubmitValid | output | 1 | Receive descriptor issue (also the allocate strobe) |
| rxSubmitWord | output | 16 | Receive descriptor word |
| txSubmitValid | output | 1 | Transmit descriptor issue (also the peek strobe) |
| txSubmitWord | output | 16 | Transmit descriptor word |
| rxRetPop | output | 1 | Consume receive return head (commit) |
| txRetPop | output | 1 | Consume transmit return head (release) |
| rxRealign | output | 1 | Realign receive read pointers to the committed multiframe |
| rxFlagClr | output | 1 | Clear receive overflow flag |
| txFlagClr | output | 1 | Clear transmit underflow flag |
| crcError | output | 1 | Receive completion reported a CRC failure |

## Verification
The main function is exercised in three ways. The first is a long random mix of levels that sit around the 16- and 80-frame thresholds, with rare alignment, overflow and underflow faults and with returns that come only while something is in flight. This separates a correct in-flight cap from an off-by-one at 4 and catches gating on the wrong level. The second is a directed idle phase in which returned words and high levels are present before enable; it shows whether idle really does nothing. The third is a directed transmit boot at 79 and then 80 unseen frames, together with returns that have each CRC flag cleared, which tells a correct threshold and CRC decode apart from a loose one.

// File: rtl/mfdc_pkg.sv
package mfdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BOOT    = 2'd1,
    ST_RUN     = 2'd2,
    ST_RECOVER = 2'd3
  } dirState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic rxPop;
    logic txPop;
    logic rxIssue;
    logic txIssue;
    logic rxRealign;
    logic rxClr;
    logic txClr;
  } ctrlStb_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic rxRetDone;
    logic txRetDone;
    logic rxCanIssue;
    logic txCanIssue;
    logic txStartOk;
    logic rxDrained;
  } dpFlags_t;

endpackage

// File: rtl/mfdc_datapath.sv
module mfdc_datapath
  import mfdc_pkg::*;
#(
  parameter int IDX_W        = 7,
  parameter int LVL_W        = 8,
  parameter int DESC_W       = 16,
  parameter int MAX_INFLIGHT = 4,
  parameter int MF_FRAMES    = 16,
  parameter int START_MF     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStb_t          stb,
  input  logic [LVL_W-1:0]  rxFreeFrames,
  input  logic [LVL_W-1:0]  txUnseenFrames,
  input  logic [IDX_W-1:0]  rxNextMf,
  input  logic [IDX_W-1:0]  txNextMf,
  input  logic [DESC_W-1:0] rxRetWord,
  input  logic [DESC_W-1:0] txRetWord,
  output dpFlags_t          flags,
  output logic [DESC_W-1:0] rxSubmitWord,
  output logic [DESC_W-1:0] txSubmitWord,
  output logic              crcError
);

  localparam int CNT_W        = $clog2(MAX_INFLIGHT + 1);
  localparam int DONE_BIT     = DESC_W - 1;
  localparam int CRC_A_BIT    = DESC_W - 2;
  localparam int CRC_B_BIT    = DESC_W - 3;
  localparam int START_FRAMES = START_MF * MF_FRAMES;
  localparam logic [LVL_W-1:0] MF_LVL    = LVL_W'(MF_FRAMES);
  localparam logic [LVL_W-1:0] START_LVL = LVL_W'(START_FRAMES);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_INFLIGHT);

  // index 0 = receive, 1 = transmit
  logic [1:0]       issueV;
  logic [1:0]       popV;
  logic [CNT_W-1:0] inFlight [2];

  assign issueV = {stb.txIssue, stb.rxIssue};
  assign popV   = {stb.txPop,   stb.rxPop};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inFlight[g] <= '0;
      end else if (issueV[g] && !popV[g]) begin
        inFlight[g] <= inFlight[g] + 1'b1;
      end else if (!issueV[g] && popV[g] && inFlight[g] != '0) begin
        inFlight[g] <= inFlight[g] - 1'b1;
      end
    end
  end

  always_comb begin
    flags.rxRetDone  = rxRetWord[DONE_BIT];
    flags.txRetDone  = txRetWord[DONE_BIT];
    flags.rxCanIssue = (inFlight[0] < CNT_MAX) && (rxFreeFrames   >= MF_LVL);
    flags.txCanIssue = (inFlight[1] < CNT_MAX) && (txUnseenFrames >= MF_LVL);
    flags.txStartOk  = txUnseenFrames >= START_LVL;
    flags.rxDrained  = inFlight[0] == '0;
  end

  assign rxSubmitWord = {{(DESC_W-IDX_W){1'b0}}, rxNextMf};
  assign txSubmitWord = {{(DESC_W-IDX_W){1'b0}}, txNextMf};
  assign crcError     = stb.rxPop &&
                        !(rxRetWord[CRC_A_BIT] && rxRetWord[CRC_B_BIT]);

endmodule

// File: rtl/mfdc_ctrl.sv
module mfdc_ctrl
  import mfdc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     rxAligned,
  input  logic     rxOverflow,
  input  logic     txUnderflow,
  input  dpFlags_t flags,
  output ctrlStb_t stb
);

  dirState_t rxState, rxNext;
  dirState_t txState, txNext;
  logic      active;

  assign active = !(rxState == ST_IDLE && txState == ST_IDLE);

  always_comb begin
    stb    = '0;
    rxNext = rxState;
    txNext = txState;
    if (!active) begin
      if (enable) begin
        rxNext = ST_BOOT;
        txNext = ST_BOOT;
      end
    end else begin
      stb.rxPop = flags.rxRetDone;
      stb.txPop = flags.txRetDone;

      unique case (rxState)
        ST_BOOT: begin
          stb.rxClr = 1'b1;
          rxNext    = ST_RUN;
        end
        ST_RUN: begin
          if (!rxAligned || rxOverflow) rxNext = ST_RECOVER;
          else stb.rxIssue = flags.rxCanIssue;
        end
        ST_RECOVER: begin
          if (flags.rxDrained) begin
            stb.rxRealign = 1'b1;
            stb.rxClr     = 1'b1;
            rxNext        = ST_RUN;
          end
        end
        default: rxNext = rxState;
      endcase

      unique case (txState)
        ST_BOOT, ST_RECOVER: begin
          if (flags.txStartOk) begin
            stb.txClr = 1'b1;
            txNext    = ST_RUN;
          end
        end
        ST_RUN: begin
          if (txUnderflow) txNext = ST_RECOVER;
          else stb.txIssue = flags.txCanIssue;
        end
        default: txNext = txState;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxState <= ST_IDLE;
      txState <= ST_IDLE;
    end else begin
      rxState <= rxNext;
      txState <= txNext;
    end
  end

endmodule

// File: rtl/mfdc_top.sv
module mfdc_top
  import mfdc_pkg::*;
#(
  parameter int IDX_W        = 7,
  parameter int LVL_W        = 8,
  parameter int DESC_W       = 16,
  parameter int MAX_INFLIGHT = 4,
  parameter int MF_FRAMES    = 16,
  parameter int START_MF     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rxAligned,
  input  logic              rxOverflow,
  input  logic              txUnderflow,
  input  logic [LVL_W-1:0]  rxFreeFrames,
  input  logic [IDX_W-1:0]  rxNextMf,
  input  logic [LVL_W-1:0]  txUnseenFrames,
  input  logic [IDX_W-1:0]  txNextMf,
  input  logic [DESC_W-1:0] rxRetWord,
  input  logic [DESC_W-1:0] txRetWord,
  output logic              rxSubmitValid,
  output logic [DESC_W-1:0] rxSubmitWord,
  output logic              txSubmitValid,
  output logic [DESC_W-1:0] txSubmitWord,
  output logic              rxRetPop,
  output logic              txRetPop,
  output logic              rxRealign,
  output logic              rxFlagClr,
  output logic              txFlagClr,
  output logic              crcError
);

  ctrlStb_t stb;
  dpFlags_t flags;

  mfdc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .rxAligned   (rxAligned),
    .rxOverflow  (rxOverflow),
    .txUnderflow (txUnderflow),
    .flags       (flags),
    .stb         (stb)
  );

  mfdc_datapath #(
    .IDX_W        (IDX_W),
    .LVL_W        (LVL_W),
    .DESC_W       (DESC_W),
    .MAX_INFLIGHT (MAX_INFLIGHT),
    .MF_FRAMES    (MF_FRAMES),
    .START_MF     (START_MF)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .stb            (stb),
    .rxFreeFrames   (rxFreeFrames),
    .txUnseenFrames (txUnseenFrames),
    .rxNextMf       (rxNextMf),
    .txNextMf       (txNextMf),
    .rxRetWord      (rxRetWord),
    .txRetWord      (txRetWord),
    .flags          (flags),
    .rxSubmitWord   (rxSubmitWord),
    .txSubmitWord   (txSubmitWord),
    .crcError       (crcError)
  );

  assign rxSubmitValid = stb.rxIssue;
  assign txSubmitValid = stb.txIssue;
  assign rxRetPop      = stb.rxPop;
  assign txRetPop      = stb.txPop;
  assign rxRealign     = stb.rxRealign;
  assign rxFlagClr     = stb.rxClr;
  assign txFlagClr     = stb.txClr;

endmodule

// File: rtl/mfdc_checker.sv
module mfdc_checker #(
  parameter int IDX_W        = 7,
  parameter int LVL_W        = 8,
  parameter int DESC_W       = 16,
  parameter int MAX_INFLIGHT = 4,
  parameter int MF_FRAMES    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [LVL_W-1:0]  txUnseenFrames,
  input logic [LVL_W-1:0]  rxFreeFrames,
  input logic [IDX_W-1:0]  rxNextMf,
  input logic [DESC_W-1:0] rxRetWord,
  input logic [DESC_W-1:0] txRetWord,
  input logic              rxSubmitValid,
  input logic [DESC_W-1:0] rxSubmitWord,
  input logic              txSubmitValid,
  input logic              rxRetPop,
  input logic              txRetPop,
  input logic              rxRealign,
  input logic              crcError
);

  localparam int CW = $clog2(MAX_INFLIGHT + 2) + 1;

  logic          started;
  logic [CW-1:0] rxCnt, txCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      rxCnt   <= '0;
      txCnt   <= '0;
    end else begin
      started <= started | enable;
      rxCnt   <= rxCnt + CW'(rxSubmitValid) - CW'(rxRetPop && rxCnt != '0);
      txCnt   <= txCnt + CW'(txSubmitValid) - CW'(txRetPop && txCnt != '0);
    end
  end

  p_desc_format_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rxSubmitValid |-> (rxSubmitWord == {{(DESC_W-IDX_W){1'b0}}, rxNextMf}));

  p_pop_needs_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rxRetPop |-> rxRetWord[DESC_W-1]) and (txRetPop |-> txRetWord[DESC_W-1]));

  p_done_gets_popped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rxRetWord[DESC_W-1]) |-> rxRetPop);

  p_rx_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rxSubmitValid |-> (rxCnt < CW'(MAX_INFLIGHT) && rxFreeFrames >= LVL_W'(MF_FRAMES)));

  p_tx_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txSubmitValid |-> (txCnt < CW'(MAX_INFLIGHT) && txUnseenFrames >= LVL_W'(MF_FRAMES)));

  p_realign_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rxRealign |-> (rxCnt == '0));

  p_crc_on_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    crcError |-> rxRetPop);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !(rxRetPop || txRetPop || rxSubmitValid || txSubmitValid));

endmodule

bind mfdc_top mfdc_checker #(
  .IDX_W        (IDX_W),
  .LVL_W        (LVL_W),
  .DESC_W       (DESC_W),
  .MAX_INFLIGHT (MAX_INFLIGHT),
  .MF_FRAMES    (MF_FRAMES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enable         (enable),
  .txUnseenFrames (txUnseenFrames),
  .rxFreeFrames   (rxFreeFrames),
  .rxNextMf       (rxNextMf),
  .rxRetWord      (rxRetWord),
  .txRetWord      (txRetWord),
  .rxSubmitValid  (rxSubmitValid),
  .rxSubmitWord   (rxSubmitWord),
  .txSubmitValid  (txSubmitValid),
  .rxRetPop       (rxRetPop),
  .txRetPop       (txRetPop),
  .rxRealign      (rxRealign),
  .crcError       (crcError)
);

// File: tb/mfdc_top_test.sv
module mfdc_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 0, BOOT = 1, RUN = 2, RECOVER = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        rxAligned = 1'b1, rxOverflow = 1'b0, txUnderflow = 1'b0;
  logic [7:0]  rxFreeFrames = '0, txUnseenFrames = '0;
  logic [6:0]  rxNextMf = '0, txNextMf = '0;
  logic [15:0] rxRetWord = '0, txRetWord = '0;
  logic        rxSubmitValid, txSubmitValid, rxRetPop, txRetPop;
  logic [15:0] rxSubmitWord, txSubmitWord;
  logic        rxRealign, rxFlagClr, txFlagClr, crcError;

  int checks = 0;
  int fails  = 0;
  int mRx = IDLE, mTx = IDLE, mRxInf = 0, mTxInf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfdc_top uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .rxAligned(rxAligned), .rxOverflow(rxOverflow), .txUnderflow(txUnderflow),
    .rxFreeFrames(rxFreeFrames), .rxNextMf(rxNextMf),
    .txUnseenFrames(txUnseenFrames), .txNextMf(txNextMf),
    .rxRetWord(rxRetWord), .txRetWord(txRetWord),
    .rxSubmitValid(rxSubmitValid), .rxSubmitWord(rxSubmitWord),
    .txSubmitValid(txSubmitValid), .txSubmitWord(txSubmitWord),
    .rxRetPop(rxRetPop), .txRetPop(txRetPop), .rxRealign(rxRealign),
    .rxFlagClr(rxFlagClr), .txFlagClr(txFlagClr), .crcError(crcError)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [15:0] descWord(logic [6:0] idx);
    return {9'b0, idx};  // R1: index in bits 6:0, rest zero
  endfunction

  // Compare outputs against the requirement model, then advance the model.
  task automatic evalCycle();
    bit eRxIss = 0, eTxIss = 0, eRxPop = 0, eTxPop = 0;
    bit eRealign = 0, eRxClr = 0, eTxClr = 0, eCrc = 0;
    int nRx = mRx, nTx = mTx;
    if (mRx == IDLE && mTx == IDLE) begin
      if (enable) begin nRx = BOOT; nTx = BOOT; end  // R10
    end else begin
      eRxPop = rxRetWord[15];
      eTxPop = txRetWord[15];
      eCrc   = eRxPop && !(rxRetWord[14] && rxRetWord[13]);
      case (mRx)
        BOOT: begin eRxClr = 1; nRx = RUN; end                      // R5
        RUN: if (!rxAligned || rxOverflow) nRx = RECOVER;            // R6
             else eRxIss = (mRxInf < 4) && (rxFreeFrames >= 16);
        RECOVER: if (mRxInf == 0) begin eRealign = 1; eRxClr = 1; nRx = RUN; end // R7
        default: ;
      endcase
      case (mTx)
        BOOT, RECOVER: if (txUnseenFrames >= 80) begin eTxClr = 1; nTx = RUN; end // R4, R8
        RUN: if (txUnderflow) nTx = RECOVER;
             else eTxIss = (mTxInf < 4) && (txUnseenFrames >= 16);
        default: ;
      endcase
    end
    check("R3/R6 rxSubmitValid", 16'(rxSubmitValid), 16'(eRxIss));
    check("R3/R8 txSubmitValid", 16'(txSubmitValid), 16'(eTxIss));
    if (eRxIss) check("R1 rxSubmitWord", rxSubmitWord, descWord(rxNextMf));
    if (eTxIss) check("R1 txSubmitWord", txSubmitWord, descWord(txNextMf));
    check("R2 rxRetPop", 16'(rxRetPop), 16'(eRxPop));
    check("R2 txRetPop", 16'(txRetPop), 16'(eTxPop));
    check("R7 rxRealign", 16'(rxRealign), 16'(eRealign));
    check("R5/R7 rxFlagClr", 16'(rxFlagClr), 16'(eRxClr));
    check("R4/R8 txFlagClr", 16'(txFlagClr), 16'(eTxClr));
    check("R9 crcError", 16'(crcError), 16'(eCrc));
    mRxInf = mRxInf + int'(eRxIss) - int'(eRxPop && mRxInf > 0);
    mTxInf = mTxInf + int'(eTxIss) - int'(eTxPop && mTxInf > 0);
    mRx = nRx;
    mTx = nTx;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    // Reset with tempting inputs: idle must stay quiet (R10)
    rxRetWord = 16'h8000; txRetWord = 16'h8000;
    rxFreeFrames = 8'd100; txUnseenFrames = 8'd100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset pop", 16'({rxRetPop, txRetPop}), 16'd0);
    check("R10 reset issue", 16'({rxSubmitValid, txSubmitValid, rxFlagClr, txFlagClr}), 16'd0);
    rst_n = 1'b1;

    // R10: returned words ignored while idle and not enabled
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1; evalCycle();
    end
    rxRetWord = '0; txRetWord = '0;

    // Enable with transmit level just under the start threshold (R4)
    @(negedge clk); enable = 1'b1; txUnseenFrames = 8'd79; rxFreeFrames = 8'd64; #1; evalCycle();
    @(negedge clk); enable = 1'b0; #1; evalCycle();   // R5 boot cycle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1; evalCycle();                // rx fills to 4, tx held at 79
    end
    @(negedge clk); txUnseenFrames = 8'd80; #1; evalCycle();  // R4 leaves boot here

    // R9 directed: each CRC flag cleared on its own
    @(negedge clk); rxRetWord = 16'hA005; #1; evalCycle();
    @(negedge clk); rxRetWord = 16'hC006; #1; evalCycle();
    @(negedge clk); rxRetWord = 16'hE007; #1; evalCycle();
    @(negedge clk); rxRetWord = '0; #1; evalCycle();

    // R6/R7 directed: overflow while descriptors are out, then drain
    @(negedge clk); rxOverflow = 1'b1; #1; evalCycle();
    @(negedge clk); rxOverflow = 1'b0; #1; evalCycle();
    while (mRxInf > 0) begin
      @(negedge clk); rxRetWord = 16'hE000; #1; evalCycle();
    end
    @(negedge clk); rxRetWord = '0; #1; evalCycle();   // realign cycle
    @(negedge clk); #1; evalCycle();

    // R8 directed: underflow then recovery at 80
    @(negedge clk); txUnderflow = 1'b1; #1; evalCycle();
    @(negedge clk); txUnderflow = 1'b0; txUnseenFrames = 8'd70; #1; evalCycle();
    @(negedge clk); txUnseenFrames = 8'd80; #1; evalCycle();

    // Random mix around the thresholds
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      enable         = ($urandom % 50) == 0;
      rxAligned      = ($urandom % 25) != 0;
      rxOverflow     = ($urandom % 40) == 0;
      txUnderflow    = ($urandom % 40) == 0;
      rxFreeFrames   = 8'($urandom_range(0, 40));
      txUnseenFrames = 8'($urandom_range(0, 120));
      rxNextMf       = 7'($urandom);
      txNextMf       = 7'($urandom);
      rxRetWord      = '0;
      txRetWord      = '0;
      if (mRxInf > 0 && ($urandom % 3) == 0)
        rxRetWord = {1'b1, (($urandom % 4) == 0) ? 2'($urandom) : 2'b11, 6'b0, 7'($urandom)};
      if (mTxInf > 0 && ($urandom % 3) == 0)
        txRetWord = {3'b111, 6'b0, 7'($urandom)};
      #1; evalCycle();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule